// File: doc/BRIEF.md
# Five-Bank Cascaded Interrupt Controller

This block gathers 160 interrupt sources into five banks of 32 lines each. A source with global number k belongs to bank k/32 at bit k%32. A rising edge on a source sets a sticky pending bit. Software clears pending bits by writing ones to them. A per-bank enable mask decides which pending bits can assert that bank's request line toward the processor. Bank n drives processor interrupt input 2+n.

Software reaches every register through a single-cycle register port. Read data is combinational. Each bank has an enable word and a status word at a stride of 0x10. One shared read-only vector word holds a 5-bit field per bank. Each field names the lowest-numbered source that is both pending and enabled in that bank. Lines 0 to 11 of bank 0 form one grouped source: they have a single enable, are cleared together, and always report as index 0.

The reset input is asynchronous and active low. Its release is synchronised inside the block, so the registers start to operate two clock edges after rst_n rises.

Top module: `cascade_intc`

## Requirements
- R1: Source input bit k belongs to bank k/32 at bit k%32. Bank n's enable word is at address n*0x10 and its status word is at n*0x10+0x4, for n = 0 to 4.
- R2: A 0-to-1 change on a source input, seen between two clock edges, sets its status bit at the second edge. The bit stays set after the source falls again, until software clears it.
- R3: Writing the status word clears each bit written as 1 and leaves each bit written as 0 unchanged. If a new rising edge arrives in the same cycle as the clear of that bit, the bit stays set.
- R4: After reset, every enable word, every status word, the vector word and irq_o read as zero.
- R5: Enable words read back what was written, apart from the group in R7. irq_o[n] is 1 exactly when bank n has at least one bit that is both set in status and enabled.
- R6: The vector word at address 0x50 holds bank n's field in bits [5n+4:5n]. Each field is the lowest index of a bit that is both pending and enabled in that bank, or 0 when there is none. Bits 31:25 read 0, and writes to this word have no effect.
- R7: In bank 0, bit 0 of an enable write sets the shared enable of lines 0 to 11. Bits 11:1 of that write are ignored. A read returns the shared enable copied onto all of bits 11:0.
- R8: A status write to bank 0 that has any of bits 11:0 set clears all twelve status bits 11:0.
- R9: When the lowest pending enabled source in bank 0 lies in lines 0 to 11, the bank 0 vector field reads 0.
- R10: Reads of addresses that hold no register return 0. Writes to those addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | 160 | Interrupt source lines, global number = bit index |
| bus_sel_i | input | 1 | Register port access in this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the same cycle as the read access |
| irq_o | output | 5 | Per-bank request, bit n goes to processor interrupt input 2+n |

## Verification
The assertions assume that the source lines are synchronous to clk and held low while reset is active. They also assume the bus address and write data are stable for the whole cycle in which bus_sel_i is high. The bench changes sources and bus signals only on the falling edge, and it keeps every source low until reset has been released. Random source activity flips only a few lines at a time, so rising edges, same-cycle clears and falling sources all occur often. The random mix of writes also includes stray writes to the vector word and to unmapped addresses, to show that they are ignored.

// File: rtl/cintc_pkg.sv
package cintc_pkg;
  typedef enum logic [1:0] {
    RK_NONE,
    RK_ENABLE,
    RK_STATUS,
    RK_VECTOR
  } reg_kind_e;
endpackage

// File: rtl/cintc_decode.sv
module cintc_decode
  import cintc_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_BANKS = 5,
  parameter int STRIDE    = 16,
  parameter int EN_OFF    = 0,
  parameter int ST_OFF    = 4,
  parameter int VEC_ADDR  = 80,
  localparam int OFF_W    = $clog2(STRIDE),
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_kind_e         kind_o,
  output logic [BANK_W-1:0] bank_o
);
  logic [ADDR_W-OFF_W-1:0] slot;
  logic [OFF_W-1:0]        off;

  assign slot = addr_i[ADDR_W-1:OFF_W];
  assign off  = addr_i[OFF_W-1:0];

  always_comb begin
    kind_o = RK_NONE;
    bank_o = BANK_W'(slot);
    if (addr_i == ADDR_W'(VEC_ADDR)) begin
      kind_o = RK_VECTOR;
    end else if (int'(slot) < NUM_BANKS) begin
      if (off == OFF_W'(EN_OFF))      kind_o = RK_ENABLE;
      else if (off == OFF_W'(ST_OFF)) kind_o = RK_STATUS;
    end
  end
endmodule

// File: rtl/cintc_lowest.sv
module cintc_lowest #(
  parameter int W   = 32,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    idx_o = '0;
    any_o = |vec_i;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/cintc_bank.sv
module cintc_bank #(
  parameter int LINES  = 32,
  parameter int GROUP  = 0,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] src_i,
  input  logic             en_we_i,
  input  logic             st_we_i,
  input  logic [LINES-1:0] wdata_i,
  output logic [LINES-1:0] en_o,
  output logic [LINES-1:0] st_o,
  output logic [IDX_W-1:0] vec_o,
  output logic             req_o
);
  localparam logic [LINES-1:0] GRP_MASK = (LINES'(1) << GROUP) - LINES'(1);

  logic [LINES-1:0] src_q, en_q, st_q;
  logic [LINES-1:0] rise, clr_val, st_clr, st_d, en_d, pend;
  logic             st_ce;
  logic [IDX_W-1:0] lo_idx;
  logic             lo_any;

  // next-state
  always_comb begin
    rise    = src_i & ~src_q;
    clr_val = wdata_i | ((|(wdata_i & GRP_MASK)) ? GRP_MASK : '0);
    st_clr  = st_we_i ? clr_val : '0;
    st_d    = (st_q & ~st_clr) | rise;
    st_ce   = st_we_i | (|rise);
    en_d    = (wdata_i & ~GRP_MASK) | (wdata_i[0] ? GRP_MASK : '0);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= '0;
    else        src_q <= src_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       st_q <= '0;
    else if (st_ce)   st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        en_q <= '0;
    else if (en_we_i)  en_q <= en_d;
  end

  assign pend  = st_q & en_q;
  assign req_o = |pend;
  assign en_o  = en_q;
  assign st_o  = st_q;

  cintc_lowest #(.W(LINES)) u_lowest (
    .vec_i (pend),
    .idx_o (lo_idx),
    .any_o (lo_any)
  );

  if (GROUP > 0) begin : g_grouped
    assign vec_o = (lo_any && int'(lo_idx) < GROUP) ? '0 : lo_idx;

    assert_group_uniform_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((en_q & GRP_MASK) == '0) || ((en_q & GRP_MASK) == GRP_MASK));
  end else begin : g_plain
    assign vec_o = lo_idx;
  end

  assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_we_i && !(|rise)) |=> ((st_q & $past(clr_val)) == '0));

  assert_rise_latches_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((st_q & $past(rise)) == $past(rise)));

  assert_status_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !st_we_i |=> ((st_q & $past(st_q)) == $past(st_q)));

  assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !req_o);

  assert_idle_vector_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !req_o |-> (vec_o == '0));
endmodule

// File: rtl/cascade_intc.sv
module cascade_intc
  import cintc_pkg::*;
#(
  parameter int NUM_BANKS   = 5,
  parameter int LINES       = 32,
  parameter int GROUP_LINES = 12,
  parameter int ADDR_W      = 8,
  parameter int STRIDE      = 16,
  parameter int VEC_ADDR    = 80,
  localparam int NSRC       = NUM_BANKS * LINES,
  localparam int IDX_W      = $clog2(LINES),
  localparam int BANK_W     = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [LINES-1:0]  bus_wdata_i,
  output logic [LINES-1:0]  bus_rdata_o,
  output logic [NUM_BANKS-1:0] irq_o
);
  logic rst_meta, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  reg_kind_e         kind;
  logic [BANK_W-1:0] bank_sel;

  cintc_decode #(
    .ADDR_W    (ADDR_W),
    .NUM_BANKS (NUM_BANKS),
    .STRIDE    (STRIDE),
    .EN_OFF    (0),
    .ST_OFF    (4),
    .VEC_ADDR  (VEC_ADDR)
  ) u_decode (
    .addr_i (bus_addr_i),
    .kind_o (kind),
    .bank_o (bank_sel)
  );

  logic [LINES-1:0]     en_all  [NUM_BANKS];
  logic [LINES-1:0]     st_all  [NUM_BANKS];
  logic [NUM_BANKS-1:0] en_we, st_we;
  logic [NUM_BANKS*IDX_W-1:0] vec_packed;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign en_we[b] = bus_sel_i && bus_we_i && (kind == RK_ENABLE) && (bank_sel == BANK_W'(b));
    assign st_we[b] = bus_sel_i && bus_we_i && (kind == RK_STATUS) && (bank_sel == BANK_W'(b));

    cintc_bank #(
      .LINES (LINES),
      .GROUP ((b == 0) ? GROUP_LINES : 0)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .src_i   (src_i[b*LINES +: LINES]),
      .en_we_i (en_we[b]),
      .st_we_i (st_we[b]),
      .wdata_i (bus_wdata_i),
      .en_o    (en_all[b]),
      .st_o    (st_all[b]),
      .vec_o   (vec_packed[b*IDX_W +: IDX_W]),
      .req_o   (irq_o[b])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_sel_i && !bus_we_i) begin
      case (kind)
        RK_ENABLE: bus_rdata_o = en_all[bank_sel];
        RK_STATUS: bus_rdata_o = st_all[bank_sel];
        RK_VECTOR: bus_rdata_o = LINES'(vec_packed);
        default:   bus_rdata_o = '0;
      endcase
    end
  end

  assert_single_target_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({en_we, st_we}));

  assert_unmapped_silent_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_sel_i && (kind == RK_NONE)) |-> (bus_rdata_o == '0));
endmodule

// File: tb/cascade_intc_tb.sv
module cascade_intc_tb;
  localparam int PERIOD = 10;
  localparam int NB = 5;
  localparam int NS = 160;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NS-1:0] src;
  logic          sel, wr;
  logic [7:0]    addr;
  logic [31:0]   wdata;
  logic [31:0]   rdata;
  logic [NB-1:0] irq;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  logic [31:0]   m_en [NB];
  logic [31:0]   m_st [NB];
  logic [NS-1:0] m_prev;

  always #(PERIOD/2) clk = ~clk;

  cascade_intc u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_i       (src),
    .bus_sel_i   (sel),
    .bus_we_i    (wr),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
    end
  endtask

  task automatic model_step(input logic [NS-1:0] s, input logic we, input logic [7:0] a, input logic [31:0] d);
    for (int b = 0; b < NB; b++) begin
      logic [31:0] rise, clr;
      rise = s[b*32 +: 32] & ~m_prev[b*32 +: 32];
      clr = 32'h0;
      if (we && a == 8'(b*16 + 4)) begin
        clr = d;
        if (b == 0 && |d[11:0]) clr[11:0] = 12'hFFF;
      end
      m_st[b] = (m_st[b] & ~clr) | rise;
      if (we && a == 8'(b*16))
        m_en[b] = (b == 0) ? {d[31:12], {12{d[0]}}} : d;
    end
    m_prev = s;
  endtask

  function automatic logic [31:0] model_vec();
    logic [31:0] v;
    v = 32'h0;
    for (int b = 0; b < NB; b++) begin
      logic [31:0] p;
      logic [4:0]  idx;
      p = m_st[b] & m_en[b];
      idx = 5'd0;
      for (int i = 31; i >= 0; i--) if (p[i]) idx = 5'(i);
      if (b == 0 && idx < 5'd12) idx = 5'd0;
      v[b*5 +: 5] = idx;
    end
    return v;
  endfunction

  function automatic logic [NB-1:0] model_irq();
    logic [NB-1:0] r;
    for (int b = 0; b < NB; b++) r[b] = |(m_st[b] & m_en[b]);
    return r;
  endfunction

  task automatic cyc(input logic [NS-1:0] s, input logic we, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    src = s; sel = we; wr = we; addr = a; wdata = d;
    @(posedge clk);
    model_step(s, we, a, d);
    #1;
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = a;
    #1;
    chk(tag, $sformatf("read %h", a), rdata, exp);
    sel = 1'b0;
  endtask

  task automatic check_all(input string tag);
    @(negedge clk);
    #1;
    chk(tag, "irq_o", 32'(irq), 32'(model_irq()));
    for (int b = 0; b < NB; b++) begin
      rd(tag, 8'(b*16), m_en[b]);
      rd(tag, 8'(b*16 + 4), m_st[b]);
    end
    rd(tag, 8'h50, model_vec());
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [NS-1:0] s;
    void'($urandom(32'd2024));
    rst_n = 1'b0; src = '0; sel = 0; wr = 0; addr = '0; wdata = '0;
    for (int b = 0; b < NB; b++) begin m_en[b] = '0; m_st[b] = '0; end
    m_prev = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R4: reset state
    check_all("R4");

    // R2: edge on global 40 (bank 1 bit 8) latches and stays after fall
    s = '0; s[40] = 1'b1;
    cyc(s, 0, 8'h0, 32'h0);
    s[40] = 1'b0;
    cyc(s, 0, 8'h0, 32'h0);
    check_all("R2");

    // R5: enabling bank 1 bit 8 raises irq_o[1], vector field 1 = 8
    cyc(s, 1, 8'h10, 32'h0000_0100);
    check_all("R5");

    // R3: write 0 keeps, write 1 clears
    cyc(s, 1, 8'h14, 32'h0);
    check_all("R3");
    cyc(s, 1, 8'h14, 32'h0000_0100);
    check_all("R3");

    // R3: new edge in the same cycle as clear keeps bit set
    s[40] = 1'b1;
    cyc(s, 1, 8'h14, 32'h0000_0100);
    s[40] = 1'b0;
    cyc(s, 0, 8'h0, 32'h0);
    check_all("R3");

    // R7: group enable follows bit 0 only
    cyc(s, 1, 8'h00, 32'h0000_0FFE);
    check_all("R7");
    cyc(s, 1, 8'h00, 32'h0000_0001);
    check_all("R7");

    // R9: group source 5 and line 20 pending, both enabled: field 0 reads 0
    cyc(s, 1, 8'h00, 32'h0010_0001);
    s[5] = 1'b1; s[20] = 1'b1;
    cyc(s, 0, 8'h0, 32'h0);
    s[5] = 1'b0; s[20] = 1'b0;
    s[9] = 1'b1;
    cyc(s, 0, 8'h0, 32'h0);
    s[9] = 1'b0;
    cyc(s, 0, 8'h0, 32'h0);
    check_all("R9");

    // R8: clearing one group bit clears all twelve
    cyc(s, 1, 8'h04, 32'h0000_0008);
    check_all("R8");

    // R10: unmapped writes ignored, reads zero
    cyc(s, 1, 8'h08, 32'hFFFF_FFFF);
    cyc(s, 1, 8'h5C, 32'hFFFF_FFFF);
    cyc(s, 1, 8'hF0, 32'hFFFF_FFFF);
    check_all("R10");
    rd("R10", 8'h08, 32'h0);
    rd("R10", 8'h0C, 32'h0);
    rd("R10", 8'h5C, 32'h0);
    rd("R10", 8'hFC, 32'h0);

    // R6: vector read-only; bank 4 field at bits 24:20
    cyc(s, 1, 8'h50, 32'hFFFF_FFFF);
    s[128+31] = 1'b1; s[128+17] = 1'b1;
    cyc(s, 1, 8'h40, 32'h8002_0000);
    check_all("R6");
    rd("R6", 8'h50, model_vec());

    // R1: random mixed traffic across all banks
    for (int it = 0; it < 600; it++) begin
      logic [31:0] d;
      logic [7:0]  a;
      logic        we;
      int          op;
      for (int w = 0; w < NB; w++)
        s[w*32 +: 32] = s[w*32 +: 32] ^ ($urandom & $urandom & $urandom);
      op = int'($urandom % 6);
      d = $urandom;
      we = 1'b1;
      case (op)
        0: begin we = 1'b0; a = 8'h0; end
        1: a = 8'(($urandom % NB) * 16);
        2: a = 8'(($urandom % NB) * 16 + 4);
        3: a = 8'h50;
        4: a = 8'($urandom);
        default: begin a = 8'(($urandom % NB) * 16 + 4); d = 32'h0; end
      endcase
      cyc(s, we, a, d);
      if (it % 8 == 7) check_all("R1");
    end
    s = '0;
    cyc(s, 0, 8'h0, 32'h0);
    check_all("R1");

    finish_run();
  end
endmodule